// File: doc/BRIEF.md
# Cascadable Dual Interval Timer

This block holds two 16-bit down-counting interval timers, A and B. Each timer has a 16-bit reload latch and an 8-bit control register, and all of them sit behind a byte-wide register bus. Software loads a reload value byte by byte, picks a tick source and a run mode, and starts the timer. When a timer passes zero, it reloads itself from its latch and sends a one-cycle pulse to an interrupt controller.

Timer A counts either system clock cycles or rising edges of an external count input. Timer B has four tick sources:
- the system clock;
- count-input edges;
- timer A underflows;
- timer A underflows that occur while the count input is high.

The last two sources let the pair act as one 32-bit counter. A timer runs either continuously or as a one-shot. A strobe bit in the control register forces an immediate reload.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both counters and both latches hold 0xFFFF, both control registers read 0x00, and both interrupt outputs are low.
- R2: A write to a timer's low-byte address (A: 0x4, B: 0x6) changes only bits 7:0 of its latch. The counter value read back does not change.
- R3: A write to a timer's high-byte address (A: 0x5, B: 0x7) sets bits 15:8 of its latch. If the timer is stopped (control bit 0 is 0), the whole new latch value is also copied into the counter. If the timer is running, the counter keeps counting.
- R4: Control bit 0 starts the timer when set. When control bit 3 is set (one-shot), an underflow also clears bit 0.
- R5: Writing control bit 4 as 1 loads the latch into the counter. Bit 4 is never stored and always reads as 0. All other control bits read back as written.
- R6: On a tick with the counter at 0, the counter reloads from the latch, so one period lasts latch+1 ticks. On any other tick, the counter decrements by 1. An underflow drives that timer's interrupt output high for exactly the next clock cycle.
- R7: A control write with bit 0 clear reloads the counter from the latch.
- R8: Timer A's control bit 5 selects its tick source: 0 counts clock cycles and 1 counts count-input rising edges.
- R9: Timer B's control bits 6:5 select its tick source: 00 is clock cycles, 01 is count-input rising edges, 10 is timer A underflows, and 11 is timer A underflows while the synchronised count input is high.
- R10: The count input passes through a two-flop synchroniser. A rising edge at the input produces one tick, applied at the third clock edge after the change.
- R11: In chained modes, a timer A underflow decrements timer B at the same clock edge.
- R12: Reads are combinational:
  - 0x4 and 0x5 return the low and high bytes of counter A;
  - 0x6 and 0x7 return the low and high bytes of counter B;
  - 0xE and 0xF return control A and control B;
  - every other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| cnt_in | input | 1 | External count input, asynchronous |
| irq_a | output | 1 | Timer A underflow pulse |
| irq_b | output | 1 | Timer B underflow pulse |

## Verification
A write or a tick takes effect at the clock edge where it is sampled, so its result appears on the read data just after that edge. An underflow interrupt follows one edge later, and a count-input edge becomes a tick at the third edge after the input changes. The bench keeps a cycle-stepped model that is updated at each edge with the same inputs. It compares read data and both interrupt outputs against that model one time unit after every edge, so each result is checked in exactly the cycle it is due. Directed phases cover reset, latch writes, one-shot, force load, stop reload and every tick source; a seeded random phase follows them.

// File: rtl/dit_pkg.sv
// Package: shared register addresses, control bit positions and
// tick-source codes for the dual interval timer.
package dit_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADR_A_LO = 4'h4;
    localparam logic [ADDR_W-1:0] ADR_A_HI = 4'h5;
    localparam logic [ADDR_W-1:0] ADR_B_LO = 4'h6;
    localparam logic [ADDR_W-1:0] ADR_B_HI = 4'h7;
    localparam logic [ADDR_W-1:0] ADR_A_CT = 4'hE;
    localparam logic [ADDR_W-1:0] ADR_B_CT = 4'hF;

    localparam int CT_RUN   = 0;
    localparam int CT_SHOT  = 3;
    localparam int CT_FORCE = 4;
    localparam int CT_SRC0  = 5;
    localparam int CT_SRC1  = 6;

    typedef enum logic [1:0] {
        SRC_CLOCK  = 2'b00,
        SRC_EDGE   = 2'b01,
        SRC_CASC   = 2'b10,
        SRC_CASC_G = 2'b11
    } tick_src_e;
endpackage

// File: rtl/cnt_sync.sv
// Module: cnt_sync
// Brings the asynchronous count input into the clock domain through a
// STAGES-deep flop chain, and flags a rising edge of the synchronised
// level with one extra flop. Assumes STAGES >= 2.
module cnt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES:0] chain_q;

    // Shift the input through the synchroniser plus one edge-detect stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], async_in};
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/interval_timer.sv
// Module: interval_timer
// One 16-bit down-counter with its reload latch and control register.
// CHAIN selects the variant: 0 gives a two-way tick source (clock or
// count edge); 1 adds the two cascade sources, fed by the neighbouring
// timer's underflow. Assumes at most one bus write per cycle.
module interval_timer
    import dit_pkg::*;
#(
    parameter bit CHAIN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ev_rise,
    input  logic              ev_level,
    input  logic              casc_uf,
    output logic [CNT_W-1:0]  count,
    output logic [BYTE_W-1:0] ctl,
    output logic              uf,
    output logic              irq
);
    logic [CNT_W-1:0]  count_q, latch_q, load_val;
    logic [BYTE_W-1:0] ctl_q;
    logic              tick_src, tick, load_now, irq_q;

    // Pick the tick source for this timer variant.
    generate
        if (CHAIN) begin : g_chain
            always_comb begin
                unique case (tick_src_e'(ctl_q[CT_SRC1:CT_SRC0]))
                    SRC_CLOCK:  tick_src = 1'b1;
                    SRC_EDGE:   tick_src = ev_rise;
                    SRC_CASC:   tick_src = casc_uf;
                    SRC_CASC_G: tick_src = casc_uf & ev_level;
                endcase
            end
        end else begin : g_plain
            logic unused_chain_in;
            assign unused_chain_in = casc_uf | ev_level;
            assign tick_src = ctl_q[CT_SRC0] ? ev_rise : 1'b1;
        end
    endgenerate

    // Decide whether a bus write reloads the counter this cycle.
    always_comb begin
        tick     = ctl_q[CT_RUN] & tick_src;
        load_now = (ctl_wr && (wdata[CT_FORCE] || !wdata[CT_RUN]))
                || (hi_wr && !ctl_q[CT_RUN]);
        load_val = hi_wr ? {wdata, latch_q[BYTE_W-1:0]} : latch_q;
        uf       = tick && (count_q == '0) && !load_now;
    end

    // Latch bytes take bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '1;
        else if (lo_wr) latch_q[BYTE_W-1:0] <= wdata;
        else if (hi_wr) latch_q[CNT_W-1:BYTE_W] <= wdata;
    end

    // Counter: a bus reload wins over a tick; a tick at zero reloads.
    always_ff @(posedge clk) begin
        if (!rst_n)        count_q <= '1;
        else if (load_now) count_q <= load_val;
        else if (tick)     count_q <= (count_q == '0) ? latch_q : count_q - 1'b1;
    end

    // Control register: the force bit is never stored; one-shot stops the timer.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ctl_q <= '0;
        else if (ctl_wr)             ctl_q <= wdata & ~(BYTE_W'(1) << CT_FORCE);
        else if (uf && ctl_q[CT_SHOT]) ctl_q[CT_RUN] <= 1'b0;
    end

    // Interrupt pulse, registered one cycle after the underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= uf;
    end

    assign count = count_q;
    assign ctl   = ctl_q;
    assign irq   = irq_q;

    a_r6_reload_on_uf: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> (count_q == $past(latch_q)));
    a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_now && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));
    a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && ctl_q[CT_SHOT] && !ctl_wr) |=> !ctl_q[CT_RUN]);
    a_r7_stop_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wdata[CT_RUN]) |=> (count_q == $past(latch_q)));
    a_r3_hi_load_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr && !ctl_q[CT_RUN]) |=> (count_q == {$past(wdata), $past(latch_q[BYTE_W-1:0])}));
    a_r6_irq_after_uf: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> irq_q);
endmodule

// File: rtl/dual_interval_timer.sv
// Module: dual_interval_timer (top)
// Two interval timers behind a byte register bus. Timer B can count
// timer A underflows in the same cycle. Reads are combinational from
// the live counters and control registers. Assumes rst_n is synchronous.
module dual_interval_timer
    import dit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cnt_in,
    output logic              irq_a,
    output logic              irq_b
);
    logic              ev_level, ev_rise;
    logic              uf_a, b_uf_unused;
    logic [CNT_W-1:0]  cnt_a, cnt_b;
    logic [BYTE_W-1:0] ctl_a, ctl_b;

    cnt_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cnt_in),
        .level(ev_level), .rise(ev_rise)
    );

    interval_timer #(.CHAIN(1'b0)) u_tmr_a (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(bus_wr && bus_addr == ADR_A_CT),
        .lo_wr (bus_wr && bus_addr == ADR_A_LO),
        .hi_wr (bus_wr && bus_addr == ADR_A_HI),
        .wdata(bus_wdata), .ev_rise(ev_rise), .ev_level(ev_level),
        .casc_uf(1'b0), .count(cnt_a), .ctl(ctl_a), .uf(uf_a), .irq(irq_a)
    );

    interval_timer #(.CHAIN(1'b1)) u_tmr_b (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(bus_wr && bus_addr == ADR_B_CT),
        .lo_wr (bus_wr && bus_addr == ADR_B_LO),
        .hi_wr (bus_wr && bus_addr == ADR_B_HI),
        .wdata(bus_wdata), .ev_rise(ev_rise), .ev_level(ev_level),
        .casc_uf(uf_a), .count(cnt_b), .ctl(ctl_b), .uf(b_uf_unused), .irq(irq_b)
    );

    // Read mux over the live counter bytes and control registers.
    always_comb begin
        unique case (bus_addr)
            ADR_A_LO: bus_rdata = cnt_a[BYTE_W-1:0];
            ADR_A_HI: bus_rdata = cnt_a[CNT_W-1:BYTE_W];
            ADR_B_LO: bus_rdata = cnt_b[BYTE_W-1:0];
            ADR_B_HI: bus_rdata = cnt_b[CNT_W-1:BYTE_W];
            ADR_A_CT: bus_rdata = ctl_a;
            ADR_B_CT: bus_rdata = ctl_b;
            default:  bus_rdata = '0;
        endcase
    end

    a_r11_chain_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_a && ctl_b[CT_RUN] && ctl_b[CT_SRC1:CT_SRC0] == 2'b10 && cnt_b != '0
         && !(bus_wr && (bus_addr == ADR_B_CT || bus_addr == ADR_B_HI)))
        |=> (cnt_b == $past(cnt_b) - 1'b1));
    a_r5_force_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_A_CT) |=> !ctl_a[CT_FORCE]);
endmodule

// File: tb/dual_interval_timer_bench.sv
// Bench: a cycle-stepped model built from the requirements, with
// directed phases followed by seeded random stimulus.
module dual_interval_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cnt_in = 1'b0;
    logic       irq_a, irq_b;

    int checks = 0;
    int errors = 0;

    // Model state
    logic [15:0] m_cnt [2];
    logic [15:0] m_lat [2];
    logic [7:0]  m_ctl [2];
    logic        m_irq [2];
    logic        s1, s2, s3;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_interval_timer u_dual_interval_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_in(cnt_in),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    function automatic logic [7:0] model_rd(input logic [3:0] a);
        case (a)
            4'h4: return m_cnt[0][7:0];
            4'h5: return m_cnt[0][15:8];
            4'h6: return m_cnt[1][7:0];
            4'h7: return m_cnt[1][15:8];
            4'hE: return m_ctl[0];
            4'hF: return m_ctl[1];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        for (int t = 0; t < 2; t++) begin
            m_cnt[t] = 16'hFFFF; m_lat[t] = 16'hFFFF;
            m_ctl[t] = 8'h00;    m_irq[t] = 1'b0;
        end
        s1 = 0; s2 = 0; s3 = 0;
    endtask

    // Advance the model by one clock edge with the inputs of this cycle.
    task automatic model_step(input logic wr, input logic [3:0] a,
                              input logic [7:0] d, input logic cin);
        logic edge_ev, lvl, uf_a;
        logic src, tk, cw, lw, hw, ld, uf;
        logic [15:0] lv;
        edge_ev = s2 & ~s3;
        lvl = s2;
        uf_a = 1'b0;
        for (int t = 0; t < 2; t++) begin
            if (t == 0) src = m_ctl[0][5] ? edge_ev : 1'b1;
            else case (m_ctl[1][6:5])
                2'b00: src = 1'b1;
                2'b01: src = edge_ev;
                2'b10: src = uf_a;
                default: src = uf_a & lvl;
            endcase
            tk = m_ctl[t][0] & src;
            cw = wr && a == (t == 0 ? 4'hE : 4'hF);
            lw = wr && a == (t == 0 ? 4'h4 : 4'h6);
            hw = wr && a == (t == 0 ? 4'h5 : 4'h7);
            ld = (cw && (d[4] || !d[0])) || (hw && !m_ctl[t][0]);
            lv = hw ? {d, m_lat[t][7:0]} : m_lat[t];
            uf = tk && m_cnt[t] == 16'h0 && !ld;
            if (t == 0) uf_a = uf;
            if (ld) m_cnt[t] = lv;
            else if (tk) m_cnt[t] = (m_cnt[t] == 0) ? m_lat[t] : m_cnt[t] - 1;
            if (lw) m_lat[t][7:0] = d;
            if (hw) m_lat[t][15:8] = d;
            if (cw) m_ctl[t] = d & 8'hEF;
            else if (uf && m_ctl[t][3]) m_ctl[t][0] = 1'b0;
            m_irq[t] = uf;
        end
        s3 = s2; s2 = s1; s1 = cin;
    endtask

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    // One bus cycle: drive, check reads, step one edge, check interrupts.
    task automatic cyc(input string tag, input logic wr, input logic [3:0] a,
                       input logic [7:0] d, input logic cin);
        bus_wr = wr; bus_addr = a; bus_wdata = d; cnt_in = cin;
        #1;
        check(tag, "rdata", bus_rdata, model_rd(a));
        @(posedge clk);
        model_step(wr, a, d, cin);
        #1;
        check(tag, "irq_a", {7'h0, irq_a}, {7'h0, m_irq[0]});
        check(tag, "irq_b", {7'h0, irq_b}, {7'h0, m_irq[1]});
    endtask

    task automatic idle(input string tag, input int n, input logic [3:0] a, input logic cin);
        for (int i = 0; i < n; i++) cyc(tag, 1'b0, a, 8'h00, cin);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'h5EED_1234);
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset values on every register
        for (int a = 0; a < 16; a++) cyc("R1", 1'b0, 4'(a), 8'h00, 1'b0);
        // R12: all addresses read back correctly
        for (int a = 0; a < 16; a++) cyc("R12", 1'b0, 4'(a), 8'h00, 1'b0);
        // R2: low byte reaches the latch only
        cyc("R2", 1'b1, 4'h4, 8'h05, 1'b0);
        cyc("R2", 1'b0, 4'h4, 8'h00, 1'b0);
        // R3: high byte loads the stopped counter
        cyc("R3", 1'b1, 4'h5, 8'h00, 1'b0);
        cyc("R3", 1'b0, 4'h4, 8'h00, 1'b0);
        // R4 / R6: one-shot on clock ticks, period latch+1
        cyc("R4", 1'b1, 4'hE, 8'h09, 1'b0);
        idle("R6", 9, 4'h4, 1'b0);
        cyc("R4", 1'b0, 4'hE, 8'h00, 1'b0);
        // R6: continuous, then R3 high write while running
        cyc("R6", 1'b1, 4'hE, 8'h01, 1'b0);
        idle("R6", 14, 4'h4, 1'b0);
        cyc("R3", 1'b1, 4'h5, 8'h01, 1'b0);
        idle("R3", 3, 4'h5, 1'b0);
        // R5: force load, bit reads as zero
        cyc("R5", 1'b1, 4'hE, 8'h11, 1'b0);
        cyc("R5", 1'b0, 4'hE, 8'h00, 1'b0);
        cyc("R5", 1'b0, 4'h5, 8'h00, 1'b0);
        // R7: stop reloads from latch
        idle("R7", 4, 4'h4, 1'b0);
        cyc("R7", 1'b1, 4'hE, 8'h00, 1'b0);
        cyc("R7", 1'b0, 4'h4, 8'h00, 1'b0);
        // R8 / R10: timer A counts count-input edges
        cyc("R8", 1'b1, 4'h4, 8'h02, 1'b0);
        cyc("R8", 1'b1, 4'h5, 8'h00, 1'b0);
        cyc("R8", 1'b1, 4'hE, 8'h21, 1'b0);
        for (int k = 0; k < 8; k++) begin
            idle("R10", 3, 4'h4, 1'b1);
            idle("R10", 3, 4'h4, 1'b0);
        end
        // R9 / R11: timer B chained to A underflows, clocked A
        cyc("R9", 1'b1, 4'hE, 8'h00, 1'b0);
        cyc("R9", 1'b1, 4'h4, 8'h01, 1'b0);
        cyc("R9", 1'b1, 4'h5, 8'h00, 1'b0);
        cyc("R9", 1'b1, 4'h6, 8'h03, 1'b0);
        cyc("R9", 1'b1, 4'h7, 8'h00, 1'b0);
        cyc("R11", 1'b1, 4'hF, 8'h41, 1'b0);
        cyc("R11", 1'b1, 4'hE, 8'h01, 1'b0);
        idle("R11", 20, 4'h6, 1'b0);
        // R9: gated cascade, count input high then low
        cyc("R9", 1'b1, 4'hF, 8'h61, 1'b1);
        idle("R9", 12, 4'h6, 1'b1);
        idle("R9", 12, 4'h6, 1'b0);
        // R9: B on edges, then on clock
        cyc("R9", 1'b1, 4'hF, 8'h21, 1'b0);
        for (int k = 0; k < 6; k++) begin
            idle("R9", 3, 4'h6, 1'b1);
            idle("R9", 3, 4'h6, 1'b0);
        end
        cyc("R9", 1'b1, 4'hF, 8'h01, 1'b0);
        idle("R9", 10, 4'h6, 1'b0);
        // Random phase over all requirements (R6, R12 dominate)
        begin
            logic c;
            c = 1'b0;
            for (int i = 0; i < 6000; i++) begin
                logic [3:0] a;
                logic [7:0] d;
                logic w;
                w = ($urandom % 8) == 0;
                a = 4'($urandom);
                d = 8'($urandom);
                if (w) begin
                    case ($urandom % 6)
                        0: a = 4'h4;
                        1: begin a = 4'h5; d = d & 8'h00; end
                        2: a = 4'h6;
                        3: begin a = 4'h7; d = d & 8'h01; end
                        4: a = 4'hE;
                        default: a = 4'hF;
                    endcase
                end
                if (($urandom % 4) == 0) c = ~c;
                cyc("R6", w, a, d, c);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule